// File: doc/BRIEF.md
# Serial-Bus Control Register Target

This block is a write-only target on a two-wire serial bus (I2C). A host addresses it, sends one sub-address byte and then any number of data bytes; the block acknowledges each byte and stores the data into a small bank of control registers. The registers drive a set of analog level settings and a set of on/off switches in parallel to the rest of the chip.

The sub-address byte does two jobs. Its low nibble selects the first register to write. Its top bit selects what happens when more data bytes follow. With the top bit clear, the register index advances after every data byte. With the top bit set, every byte lands in the same register, which suits a host that keeps refreshing one setting. Each stored byte holds a 7-bit level in its low bits and one switch in its top bit, so fifteen levels and thirteen switches fit in sixteen sub-addresses. Register contents cannot be read back, so the host writes every setting after power-up.

SCL and SDA are sampled with the system clock through synchronisers, so SCL must stay in each phase for several system clocks. The block has no streaming data path. All pins are plain level signals and nothing applies back-pressure. The host cannot be stalled, because the block never stretches the clock.

Top module: `ctl_reg_i2c_target`

## Requirements
- R1: After reset, every level field and switch output is 0 and SDA is not pulled low.
- R2: The block acknowledges the address byte 0x8A, which is target address 0x45 followed by R/W bit 0. It also acknowledges the sub-address byte and every data byte after it. To acknowledge, it pulls SDA low through the ninth SCL clock of the byte, and it asserts the pull-down only after an SCL falling edge.
- R3: An address byte other than 0x8A, including the read request 0x8B, is not acknowledged. The block also ignores every later byte until the next START.
- R4: When sub-address bit 7 is 0 (upper nibble 0x0), the first data byte goes to the register named by sub-address bits 3:0. Each following data byte goes to the next index.
- R5: When sub-address bit 7 is 1 (upper nibble 0x8), every data byte goes to the register named by sub-address bits 3:0.
- R6: Registers exist at indices 0 to 14. A data byte for index 15 is acknowledged and then discarded, and no output changes.
- R7: In auto-increment mode the index stops advancing at 14. Further bytes overwrite register 14.
- R8: Data bits 6:0 of register i appear on `dac_o[7*i+6:7*i]`. For i below 13, data bit 7 of register i appears on `sw_o[i]`. Bit 7 of registers 13 and 14 is dropped.
- R9: A START or STOP that arrives while a byte is incomplete abandons that byte. Nothing is written, and SDA is released. After a repeated START the next byte is treated as an address byte.
- R10: Outputs change only for a completed data byte. The new value appears within 4 system clocks after the SCL falling edge that ends that byte's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When 1, pull the data line low |
| dac_o | output | 105 | Fifteen 7-bit level settings, register 0 in the lowest bits |
| sw_o | output | 13 | Switch bits, bit i from register i |

## Verification
A data byte commits and the register index steps in the same system clock. At the last register, that cycle also has to saturate the index. The bench provokes this by starting an auto-increment burst at index 13 with four bytes. Its reference model expects register 14 to take the second, third and fourth bytes in turn while register 13 keeps the first. The bench also starts a burst at index 15, where commit, discard and the frozen index all meet, and expects no output to move.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/ctl_i2c_line_sync.sv
module ctl_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ctl_i2c_byte_fsm.sv
module ctl_i2c_byte_fsm
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45,
  parameter int         IDX_W    = 4,
  parameter int         LAST_IDX = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [3:0]        FULL    = 4'(BYTE_W);

  phase_e            phase;
  logic [3:0]        bit_cnt;
  logic              in_ack;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  ptr;
  logic              refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      shreg     <= '0;
      ptr       <= '0;
      refresh   <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det || stop_det) begin
        phase    <= start_det ? PH_ADDR : PH_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
        if (scl_rise && !in_ack && bit_cnt < FULL) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && !in_ack && bit_cnt == FULL) begin
          bit_cnt <= '0;
          if (phase == PH_ADDR && shreg != WR_ADDR) begin
            phase <= PH_SKIP;
          end else begin
            in_ack   <= 1'b1;
            sda_oe_o <= 1'b1;
          end
        end else if (scl_fall && in_ack) begin
          in_ack   <= 1'b0;
          sda_oe_o <= 1'b0;
          case (phase)
            PH_ADDR: phase <= PH_SUB;
            PH_SUB: begin
              ptr     <= shreg[IDX_W-1:0];
              refresh <= shreg[BYTE_W-1];
              phase   <= PH_DATA;
            end
            PH_DATA: begin
              wr_en_o   <= 1'b1;
              wr_idx_o  <= ptr;
              wr_data_o <= shreg;
              if (!refresh && ptr < IDX_W'(LAST_IDX)) ptr <= ptr + IDX_W'(1);
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ctl_i2c_reg_bank.sv
module ctl_i2c_reg_bank #(
  parameter int NUM_REG = 15,
  parameter int DAC_W   = 7,
  parameter int NUM_SW  = 13,
  parameter int IDX_W   = 4,
  parameter int REG_W   = DAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [REG_W-1:0]         wr_data,
  output logic [NUM_REG*DAC_W-1:0] dac_o,
  output logic [NUM_SW-1:0]        sw_o
);
  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    logic [DAC_W-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i)) lvl_q <= wr_data[DAC_W-1:0];
    end
    assign dac_o[i*DAC_W +: DAC_W] = lvl_q;

    if (i < NUM_SW) begin : g_sw
      logic sw_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= 1'b0;
        else if (wr_en && wr_idx == IDX_W'(i)) sw_q <= wr_data[REG_W-1];
      end
      assign sw_o[i] = sw_q;
    end
  end
endmodule

// File: rtl/ctl_reg_i2c_target.sv
module ctl_reg_i2c_target
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter int         NUM_DAC     = 15,
  parameter int         DAC_W       = 7,
  parameter int         NUM_SW      = 13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  output logic [NUM_DAC*DAC_W-1:0] dac_o,
  output logic [NUM_SW-1:0]        sw_o
);
  localparam int IDX_W    = 4;
  localparam int LAST_IDX = NUM_DAC - 1;

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  ctl_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ctl_i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  ctl_i2c_reg_bank #(.NUM_REG(NUM_DAC), .DAC_W(DAC_W), .NUM_SW(NUM_SW), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dac_o(dac_o), .sw_o(sw_o)
  );
endmodule

// File: rtl/ctl_reg_i2c_chk.sv
module ctl_reg_i2c_chk #(
  parameter int DW       = 105,
  parameter int SW       = 13,
  parameter int IDX_W    = 4,
  parameter int LAST_IDX = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    dac,
  input logic [SW-1:0]    sw
);
  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R2
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!sda_oe && !wr_en)); // R9
  AST_COMMIT_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!sda_oe && $past(sda_oe))); // R10
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dac) && $stable(sw))); // R10
  AST_HIGH_INDEX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > IDX_W'(LAST_IDX)) |=> ($stable(dac) && $stable(sw))); // R6
endmodule

bind ctl_reg_i2c_target ctl_reg_i2c_chk #(
  .DW(NUM_DAC*DAC_W), .SW(NUM_SW), .IDX_W(IDX_W), .LAST_IDX(LAST_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
  .dac(dac_o), .sw(sw_o)
);

// File: tb/ctl_reg_i2c_target_bench.sv
module ctl_reg_i2c_target_bench;
  localparam int NREG = 15;
  localparam int LW   = 7;
  localparam int NSW  = 13;
  localparam int HP   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*LW-1:0] dac_o;
  logic [NSW-1:0]     sw_o;

  logic [NREG*LW-1:0] exp_dac = '0;
  logic [NSW-1:0]     exp_sw  = '0;
  int  errors = 0;
  int  checks = 0;
  bit  mon_en = 0;
  bit  settle = 0;
  bit  done = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  ctl_reg_i2c_target u_ctl_reg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dac_o(dac_o), .sw_o(sw_o)
  );

  // Reference comparison on every clock, outside the commit window (R10)
  always @(negedge clk) begin
    #1;
    if (mon_en && !settle && !done) begin
      checks++;
      if (dac_o !== exp_dac || sw_o !== exp_sw) begin
        errors++;
        $display("FAIL R10 per-clock: dac=%h sw=%h expected dac=%h sw=%h",
                 dac_o, sw_o, exp_dac, exp_sw);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_write(input int idx, input logic [7:0] b);
    if (idx < NREG) exp_dac[idx*LW +: LW] = b[6:0];
    if (idx < NSW)  exp_sw[idx] = b[7];
  endtask

  task automatic check_regs(input string rq);
    tick(1);
    checks++;
    if (dac_o !== exp_dac || sw_o !== exp_sw) begin
      errors++;
      $display("FAIL %s snapshot: dac=%h sw=%h expected dac=%h sw=%h",
               rq, dac_o, sw_o, exp_dac, exp_sw);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(HP);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0;
    end
  endtask

  // widx < 0: no register update expected for this byte
  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input string rq, input int widx);
    send_bits(b, 8);
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    checks++;
    if (sda_line !== !exp_ack) begin
      errors++;
      $display("FAIL %s ack of byte %h: sda=%0b expected %0b", rq, b, sda_line, !exp_ack);
    end
    tick(HP/2);
    scl_m = 1'b0;
    settle = 1;
    tick(6);
    if (widx >= 0) model_write(widx, b);
    settle = 0;
    tick(HP - 6);
  endtask

  task automatic write_txn(input logic [7:0] addr, input logic [7:0] sub,
                           input logic [7:0] data[$], input string rq);
    bit ok;
    int ptr;
    ok = (addr == 8'h8A);
    bus_start();
    send_byte(addr, ok, ok ? "R2" : "R3", -1);
    send_byte(sub, ok, ok ? "R2" : "R3", -1);
    ptr = int'(sub[3:0]);
    foreach (data[k]) begin
      send_byte(data[k], ok, rq, (ok && ptr < NREG) ? ptr : -1);
      if (!sub[7] && ptr < NREG - 1) ptr++;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): run still active, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d[$];
    tick(5);
    // R1: reset state
    checks++;
    if (dac_o !== '0 || sw_o !== '0 || sda_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: dac=%h sw=%h oe=%0b expected 0 0 0", dac_o, sw_o, sda_oe);
    end
    rst_n = 1'b1;
    tick(5);
    mon_en = 1;

    // R4 / R8: auto-increment fill of all registers
    d = {};
    for (int i = 0; i < NREG; i++) d.push_back(8'((i * 37 + 5) ^ (i[0] ? 8'h80 : 8'h00)));
    write_txn(8'h8A, 8'h00, d, "R4");
    check_regs("R8");

    // R5: refresh keeps writing register 5
    d = {8'h12, 8'h9F, 8'h7E};
    write_txn(8'h8A, 8'h85, d, "R5");
    check_regs("R5");

    // R7: start at 13, saturates at 14
    d = {8'hC1, 8'h22, 8'hB3, 8'h44};
    write_txn(8'h8A, 8'h0D, d, "R7");
    check_regs("R7");

    // R6: index 15 acknowledged, discarded (auto and refresh)
    d = {8'hFF, 8'h00};
    write_txn(8'h8A, 8'h0F, d, "R6");
    write_txn(8'h8A, 8'h8F, d, "R6");
    check_regs("R6");

    // R3: wrong address and read request ignored
    d = {8'h00, 8'h00};
    write_txn(8'h8C, 8'h01, d, "R3");
    write_txn(8'h8B, 8'h02, d, "R3");
    check_regs("R3");

    // R9: repeated START mid-byte, then a fresh transfer
    bus_start();
    send_byte(8'h8A, 1, "R9", -1);
    send_byte(8'h03, 1, "R9", -1);
    send_byte(8'h55, 1, "R9", 3);
    send_bits(8'hAA, 5);
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(HP);
    send_byte(8'h8A, 1, "R9", -1);
    send_byte(8'h86, 1, "R9", -1);
    send_byte(8'h11, 1, "R9", 6);
    bus_stop();
    check_regs("R9");

    // R9: STOP mid-byte writes nothing
    bus_start();
    send_byte(8'h8A, 1, "R9", -1);
    send_byte(8'h02, 1, "R9", -1);
    send_bits(8'hE7, 3);
    bus_stop();
    check_regs("R9");
    checks++;
    if (sda_oe !== 1'b0) begin
      errors++;
      $display("FAIL R9 release: oe=%0b expected 0", sda_oe);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule